// File: doc/BRIEF.md
# I2C Master Message Sequencer

This block runs one complete I2C message as a controller. It sits above a bit-level byte engine that drives the bus lines. The sequencer breaks the message into engine commands and checks each response. It issues START, sends a 7-bit or 10-bit target address and sends or collects the data bytes. It then closes the bus with STOP, even when the message has failed. A caller gives the address, the direction, a byte count and mode flags, then pulses `start`. Write bytes are pulled one at a time through `wr_take`/`wr_data`. Received bytes come out on `rd_valid`/`rd_data`. At the end, `done` pulses once, and `err` and `xfer_count` report the outcome.

The sequencer does more than a plain byte-level master. When an address byte is not acknowledged, it retries: it issues STOP, waits a fixed gap, issues START and sends the address again. A 10-bit read turns the bus around with a repeated START. In length-prefixed read mode, the first received byte sets how many more bytes follow.

The engine interface takes one command at a time. The sequencer pulses `eng_go` with a command code, and the engine answers with a single-cycle `eng_done` together with its response flags.

Top module: `i2c_msg_seq`

## Requirements
- R1: A `start` pulse while idle latches all message inputs and raises `busy`. The first engine command of the message is START (code 0). Engine command codes: 0 START, 1 STOP, 2 repeated START, 3 write byte, 4 read byte, 5 send acknowledge bit (`eng_bit` 1 = ACK, 0 = NAK).
- R2: In 7-bit mode the address byte is `{addr[6:0], rd ^ flip_dir}`.
- R3: In 10-bit mode the sequencer writes two address bytes: first `{5'b11110, addr[9:8], 1'b0}`, then `addr[7:0]`. For a read, it then issues a repeated START and writes the first byte again with bit 0 set.
- R4: An address byte that gets a NAK (`eng_nak`=1) is retried. Each retry issues STOP, waits at least GAP_CYCLES idle cycles, issues START and writes the address again. At most RETRIES retries are made; after that the message ends with error code 1. The second byte of a 10-bit address is not retried.
- R5: With `ignore_nak` set, no retry is made and no NAK on an address or data byte aborts the message. Every byte counts as completed.
- R6: A write pulses `wr_take` once per data byte and sends the bytes in order. A data NAK aborts the message with error code 2. `xfer_count` then holds the number of bytes acknowledged before it.
- R7: A read follows each received byte with an acknowledge command: ACK for every byte but the last, NAK for the last. Each received byte is presented once on `rd_valid`/`rd_data`.
- R8: In length-prefixed mode (`recv_len`), the first received byte v is added to the remaining count when 1 <= v <= 32. Any other v is answered with NAK and the message ends with error code 4.
- R9: Every message ends with a STOP command before `done`, whether it succeeds or fails.
- R10: An engine timeout (`eng_to` with `eng_done`) on any command other than STOP ends the message with error code 3 through STOP.
- R11: `done` is a single-cycle pulse. `err` (0 ok, 1 address NAK, 2 data NAK, 3 timeout, 4 bad length) and `xfer_count` hold their values until the next accepted `start`.
- R12: A `start` pulse while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a message (accepted only when idle) |
| addr | input | 10 | Target address (7-bit mode uses bits 6:0) |
| rd | input | 1 | 1 = read message, 0 = write message |
| ten_bit | input | 1 | Use 10-bit addressing |
| flip_dir | input | 1 | Invert the direction bit of a 7-bit address byte |
| ignore_nak | input | 1 | Do not retry or abort on NAK |
| recv_len | input | 1 | First read byte extends the count |
| len | input | CW | Number of data bytes |
| wr_data | input | 8 | Next write byte, taken when `wr_take` is high |
| wr_take | output | 1 | Consumes `wr_data` this cycle |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` valid this cycle |
| busy | output | 1 | Message in progress |
| done | output | 1 | Message finished (one cycle) |
| err | output | 3 | Outcome code |
| xfer_count | output | CW+1 | Bytes completed |
| eng_go | output | 1 | Command strobe to the byte engine |
| eng_cmd | output | 3 | Command code |
| eng_byte | output | 8 | Byte to write |
| eng_bit | output | 1 | Acknowledge bit to send |
| eng_done | input | 1 | Engine finished the current command |
| eng_nak | input | 1 | Written byte was not acknowledged |
| eng_to | input | 1 | Engine timed out on the clock line |
| eng_rx | input | 8 | Byte received by the engine |

## Verification
A command reaches the engine on the second rising edge after its step is entered: one edge to decide and one to register `eng_go`. The next command follows two edges after `eng_done` is seen. `rd_valid` rises on the edge that takes the read response, and `done` rises on the edge that takes the STOP response. The bench model of the engine samples `eng_go` and drives its responses on falling edges, so every value is stable across the rising edge that consumes it. Status is read only after the bench has counted the `done` pulse. The retry gap is checked as a lower bound on the falling-edge cycle distance between the retry STOP and START commands: GAP_CYCLES plus the engine latency.

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq #(
  parameter int CW = 8,
  parameter int RETRIES = 3,
  parameter int GAP_CYCLES = 16,
  parameter int MAX_BLOCK = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [9:0]    addr,
  input  logic          rd,
  input  logic          ten_bit,
  input  logic          flip_dir,
  input  logic          ignore_nak,
  input  logic          recv_len,
  input  logic [CW-1:0] len,
  input  logic [7:0]    wr_data,
  output logic          wr_take,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  output logic          busy,
  output logic          done,
  output logic [2:0]    err,
  output logic [CW:0]   xfer_count,
  output logic          eng_go,
  output logic [2:0]    eng_cmd,
  output logic [7:0]    eng_byte,
  output logic          eng_bit,
  input  logic          eng_done,
  input  logic          eng_nak,
  input  logic          eng_to,
  input  logic [7:0]    eng_rx
);
  localparam int RW = CW + 1;
  localparam int TW = $clog2(RETRIES + 2);
  localparam int GW = $clog2(GAP_CYCLES + 1);

  localparam logic [2:0] C_START = 3'd0, C_STOP = 3'd1, C_RSTART = 3'd2,
                         C_WRITE = 3'd3, C_READ = 3'd4, C_ACK = 3'd5;
  localparam logic [2:0] E_OK = 3'd0, E_ADDR = 3'd1, E_DATA = 3'd2,
                         E_TIME = 3'd3, E_LEN = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_A0, S_A1, S_RS, S_A2, S_XFER, S_ACK,
    S_STOP, S_RSTOP, S_GAP, S_RSTART
  } step_t;

  step_t step, after_addr;
  logic pend, m_rd, m_ten, m_flip, m_ign, m_rlen;
  logic first_rd, bad_len, ack_bit, retry_a2;
  logic [9:0] m_addr;
  logic [RW-1:0] remain, cnt;
  logic [TW-1:0] tries;
  logic [GW-1:0] gap;
  logic [7:0] b7, b10, byte_n;
  logic [2:0] cmd_n;
  logic issue, resp, len_bad;

  assign b7      = {m_addr[6:0], m_rd ^ m_flip};
  assign b10     = {5'b11110, m_addr[9:8], 1'b0};
  assign busy    = step != S_IDLE;
  assign issue   = busy && !pend && step != S_GAP;
  assign wr_take = issue && step == S_XFER && !m_rd;
  assign resp    = pend && eng_done;
  assign len_bad = eng_rx == 8'd0 || eng_rx > 8'(MAX_BLOCK);
  assign xfer_count = cnt;
  assign after_addr = (remain == '0) ? S_STOP : S_XFER;

  always_comb begin
    case (step)
      S_START, S_RSTART: cmd_n = C_START;
      S_RS:              cmd_n = C_RSTART;
      S_STOP, S_RSTOP:   cmd_n = C_STOP;
      S_ACK:             cmd_n = C_ACK;
      S_XFER:            cmd_n = m_rd ? C_READ : C_WRITE;
      default:           cmd_n = C_WRITE;
    endcase
    case (step)
      S_A0:    byte_n = m_ten ? b10 : b7;
      S_A1:    byte_n = m_addr[7:0];
      S_A2:    byte_n = b10 | 8'h01;
      S_XFER:  byte_n = wr_data;
      default: byte_n = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= S_IDLE; pend <= 1'b0;
      m_rd <= 1'b0; m_ten <= 1'b0; m_flip <= 1'b0; m_ign <= 1'b0; m_rlen <= 1'b0;
      m_addr <= '0; remain <= '0; cnt <= '0; tries <= '0; gap <= '0;
      first_rd <= 1'b0; bad_len <= 1'b0; ack_bit <= 1'b0; retry_a2 <= 1'b0;
      err <= E_OK; done <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
      eng_go <= 1'b0; eng_cmd <= C_START; eng_byte <= '0; eng_bit <= 1'b0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      eng_go   <= issue;
      if (issue) begin
        eng_cmd <= cmd_n; eng_byte <= byte_n; eng_bit <= ack_bit; pend <= 1'b1;
      end else if (resp) begin
        pend <= 1'b0;
      end
      case (step)
        S_IDLE: if (start) begin
          m_addr <= addr; m_rd <= rd; m_ten <= ten_bit; m_flip <= flip_dir;
          m_ign <= ignore_nak; m_rlen <= recv_len;
          remain <= RW'(len); cnt <= '0; err <= E_OK;
          tries <= ignore_nak ? '0 : TW'(RETRIES);
          first_rd <= 1'b1; bad_len <= 1'b0; retry_a2 <= 1'b0;
          step <= S_START;
        end
        S_GAP: begin
          if (gap == GW'(GAP_CYCLES - 1)) step <= S_RSTART;
          else gap <= gap + GW'(1);
        end
        S_STOP: if (resp) begin
          if (eng_to && err == E_OK) err <= E_TIME;
          done <= 1'b1;
          step <= S_IDLE;
        end
        S_RSTOP: if (resp) begin
          gap <= '0;
          step <= S_GAP;
        end
        default: if (resp) begin
          if (eng_to) begin
            err <= E_TIME; step <= S_STOP;
          end else begin
            case (step)
              S_START:  step <= S_A0;
              S_RSTART: step <= retry_a2 ? S_A2 : S_A0;
              S_RS: begin
                tries <= m_ign ? '0 : TW'(RETRIES);
                step <= S_A2;
              end
              S_A0, S_A2: begin
                if (!eng_nak || m_ign) begin
                  if (step == S_A0 && m_ten) step <= S_A1;
                  else step <= after_addr;
                end else if (tries != '0) begin
                  tries <= tries - TW'(1);
                  retry_a2 <= step == S_A2;
                  step <= S_RSTOP;
                end else begin
                  err <= E_ADDR; step <= S_STOP;
                end
              end
              S_A1: begin
                if (eng_nak && !m_ign) begin
                  err <= E_ADDR; step <= S_STOP;
                end else begin
                  step <= m_rd ? S_RS : after_addr;
                end
              end
              S_XFER: begin
                if (m_rd) begin
                  rd_data <= eng_rx; rd_valid <= 1'b1;
                  cnt <= cnt + RW'(1); first_rd <= 1'b0;
                  if (m_rlen && first_rd) begin
                    if (len_bad) begin
                      bad_len <= 1'b1; ack_bit <= 1'b0;
                    end else begin
                      remain <= remain + RW'(eng_rx) - RW'(1); ack_bit <= 1'b1;
                    end
                  end else begin
                    remain <= remain - RW'(1); ack_bit <= remain != RW'(1);
                  end
                  step <= S_ACK;
                end else if (eng_nak && !m_ign) begin
                  err <= E_DATA; step <= S_STOP;
                end else begin
                  cnt <= cnt + RW'(1);
                  remain <= remain - RW'(1);
                  step <= (remain == RW'(1)) ? S_STOP : S_XFER;
                end
              end
              S_ACK: begin
                if (bad_len) begin
                  err <= E_LEN; step <= S_STOP;
                end else begin
                  step <= (remain == '0) ? S_STOP : S_XFER;
                end
              end
              default: step <= S_STOP;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_msg_seq_chk.sv
module i2c_msg_seq_chk #(
  parameter int CW = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [2:0]  err,
  input logic        eng_go,
  input logic [2:0]  eng_cmd,
  input logic        wr_take,
  input logic        rd_valid,
  input logic [CW:0] xfer_count
);
  logic fresh, saw_wr, saw_rd;
  logic [2:0] last_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh <= 1'b0; saw_wr <= 1'b0; saw_rd <= 1'b0; last_cmd <= 3'd0;
    end else begin
      if (start && !busy) begin
        fresh <= 1'b1; saw_wr <= 1'b0; saw_rd <= 1'b0;
      end else begin
        if (eng_go) fresh <= 1'b0;
        if (wr_take) saw_wr <= 1'b1;
        if (rd_valid) saw_rd <= 1'b1;
      end
      if (eng_go) last_cmd <= eng_cmd;
    end
  end

  a_r1_start_first: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_go && fresh) |-> eng_cmd == 3'd0);

  a_r7_ack_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_go && eng_cmd == 3'd5) |-> last_cmd == 3'd4);

  a_r9_stop_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> last_cmd == 3'd1);

  a_r6_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(saw_wr && rd_valid) && !(saw_rd && wr_take));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && !start) |=> ($stable(err) && $stable(xfer_count)));

  a_r10_err_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> err <= 3'd4);
endmodule

bind i2c_msg_seq i2c_msg_seq_chk #(.CW(CW)) u_chk (.*);

// File: tb/i2c_msg_seq_test.sv
module i2c_msg_seq_test;
  localparam int CW = 8;
  localparam int GAP = 16;
  localparam int LAT = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, rd, ten_bit, flip_dir, ignore_nak, recv_len;
  logic [9:0] addr;
  logic [CW-1:0] len;
  logic [7:0] wr_data, rd_data, eng_byte, eng_rx;
  logic wr_take, rd_valid, busy, done, eng_go, eng_bit, eng_done, eng_nak, eng_to;
  logic [2:0] err, eng_cmd;
  logic [CW:0] xfer_count;

  i2c_msg_seq uut (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [2:0] lc [0:255];
  logic [7:0] lb [0:255];
  logic       lbit [0:255];
  int         lcyc [0:255];
  int ncmd = 0;
  logic [2:0] ec [0:255];
  logic [7:0] eb [0:255];
  logic       ebit [0:255];
  int ne = 0;
  logic [63:0] nak_wr = '0;
  int wcnt = 0, to_at = -1, rxi = 0, wr_ptr = 0, nrd = 0, ndone = 0;
  logic take_seen = 1'b0;
  logic [7:0] rx_src [0:63];
  logic [7:0] wr_src [0:15];
  logic [7:0] rd_log [0:63];

  assign wr_data = wr_src[wr_ptr[3:0]];

  initial forever begin
    @(negedge clk);
    cyc++;
    if (take_seen) wr_ptr++;
    take_seen = wr_take;
    if (rd_valid) begin rd_log[nrd] = rd_data; nrd++; end
    if (done) ndone++;
  end

  initial begin
    eng_done = 0; eng_nak = 0; eng_to = 0; eng_rx = 0;
    forever begin
      @(negedge clk);
      if (eng_go) begin
        int k;
        k = ncmd;
        lc[k] = eng_cmd; lb[k] = eng_byte; lbit[k] = eng_bit; lcyc[k] = cyc;
        ncmd++;
        repeat (LAT) @(negedge clk);
        eng_to = (k == to_at);
        if (lc[k] == 3'd3) begin eng_nak = nak_wr[wcnt]; wcnt++; end
        if (lc[k] == 3'd4) begin eng_rx = rx_src[rxi]; rxi++; end
        eng_done = 1;
        @(negedge clk);
        eng_done = 0; eng_nak = 0; eng_to = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic prep();
    ncmd = 0; wcnt = 0; rxi = 0; nak_wr = '0; to_at = -1;
    wr_ptr = 0; nrd = 0; ne = 0;
  endtask

  task automatic e(input logic [2:0] c, input logic [7:0] b = 8'h00, input logic bt = 1'b0);
    ec[ne] = c; eb[ne] = b; ebit[ne] = bt; ne++;
  endtask

  task automatic cmp_log(input string req);
    chk(ncmd == ne, req, "command count", ncmd, ne);
    for (int i = 0; i < ne && i < ncmd; i++) begin
      chk(lc[i] == ec[i], req, $sformatf("cmd %0d code", i), lc[i], ec[i]);
      if (ec[i] == 3'd3) chk(lb[i] == eb[i], req, $sformatf("cmd %0d byte", i), lb[i], eb[i]);
      if (ec[i] == 3'd5) chk(lbit[i] == ebit[i], req, $sformatf("cmd %0d ack bit", i), lbit[i], ebit[i]);
    end
  endtask

  task automatic pulse_start(input logic [9:0] a, input logic r, input logic t, input logic f,
                             input logic i, input logic l, input logic [7:0] n);
    @(negedge clk);
    addr = a; rd = r; ten_bit = t; flip_dir = f; ignore_nak = i; recv_len = l; len = n;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(input int d0, input string req);
    int w;
    w = 0;
    while (ndone == d0 && w < 5000) begin @(negedge clk); w++; end
    chk(w < 5000, req, "message completion", w, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input logic [9:0] a, input logic r, input logic t, input logic f,
                     input logic i, input logic l, input logic [7:0] n, input string req);
    int d0;
    d0 = ndone;
    pulse_start(a, r, t, f, i, l, n);
    wait_done(d0, req);
  endtask

  task automatic t_reset();
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    chk(done == 0, "R11", "done after reset", done, 0);
    chk(eng_go == 0 && wr_take == 0, "R1", "engine idle after reset", eng_go, 0);
  endtask

  task automatic t_write7();
    prep(); wr_src[0] = 8'h3C; wr_src[1] = 8'hC3;
    run(10'h052, 0, 0, 0, 0, 0, 2, "R2");
    e(0); e(3, 8'hA4); e(3, 8'h3C); e(3, 8'hC3); e(1);
    cmp_log("R2 R6 R9");
    chk(err == 0, "R6", "err", err, 0);
    chk(xfer_count == 2, "R6", "count", xfer_count, 2);
  endtask

  task automatic t_read7_flip();
    prep(); rx_src[0] = 8'h11; rx_src[1] = 8'h22; rx_src[2] = 8'h33;
    run(10'h01B, 1, 0, 1, 0, 0, 3, "R7");
    e(0); e(3, 8'h36); e(4); e(5, 0, 1); e(4); e(5, 0, 1); e(4); e(5, 0, 0); e(1);
    cmp_log("R2 R7");
    chk(nrd == 3, "R7", "bytes delivered", nrd, 3);
    chk(rd_log[0] == 8'h11 && rd_log[1] == 8'h22 && rd_log[2] == 8'h33, "R7", "read data", rd_log[2], 8'h33);
    chk(err == 0 && xfer_count == 3, "R7", "status count", xfer_count, 3);
  endtask

  task automatic t_retry_ok();
    prep(); nak_wr = 64'h3; wr_src[0] = 8'h5A;
    run(10'h010, 0, 0, 0, 0, 0, 1, "R4");
    e(0); e(3, 8'h20); e(1); e(0); e(3, 8'h20); e(1); e(0); e(3, 8'h20); e(3, 8'h5A); e(1);
    cmp_log("R4");
    chk(err == 0 && xfer_count == 1, "R4", "status after retries", err, 0);
    chk(lcyc[3] - lcyc[2] >= GAP + LAT, "R4", "retry gap", lcyc[3] - lcyc[2], GAP + LAT);
  endtask

  task automatic t_retry_exhaust();
    prep(); nak_wr = '1; wr_src[0] = 8'h5A;
    run(10'h010, 0, 0, 0, 0, 0, 1, "R4");
    e(0); e(3, 8'h20);
    for (int i = 0; i < 3; i++) begin e(1); e(0); e(3, 8'h20); end
    e(1);
    cmp_log("R4 R9");
    chk(err == 1, "R4", "address nak err", err, 1);
    chk(xfer_count == 0, "R4", "count", xfer_count, 0);
  endtask

  task automatic t_ignore();
    prep(); nak_wr = '1; wr_src[0] = 8'hAA; wr_src[1] = 8'h55;
    run(10'h010, 0, 0, 0, 1, 0, 2, "R5");
    e(0); e(3, 8'h20); e(3, 8'hAA); e(3, 8'h55); e(1);
    cmp_log("R5");
    chk(err == 0 && xfer_count == 2, "R5", "ignore nak status", xfer_count, 2);
  endtask

  task automatic t_data_nak();
    prep(); nak_wr = 64'h4; wr_src[0] = 8'h01; wr_src[1] = 8'h02; wr_src[2] = 8'h03;
    run(10'h010, 0, 0, 0, 0, 0, 3, "R6");
    e(0); e(3, 8'h20); e(3, 8'h01); e(3, 8'h02); e(1);
    cmp_log("R6 R9");
    chk(err == 2, "R6", "data nak err", err, 2);
    chk(xfer_count == 1, "R6", "count", xfer_count, 1);
  endtask

  task automatic t_ten_write();
    prep(); wr_src[0] = 8'h77;
    run(10'h2A5, 0, 1, 0, 0, 0, 1, "R3");
    e(0); e(3, 8'hF4); e(3, 8'hA5); e(3, 8'h77); e(1);
    cmp_log("R3");
    chk(err == 0, "R3", "err", err, 0);
  endtask

  task automatic t_ten_read();
    prep(); rx_src[0] = 8'h9E;
    run(10'h1C3, 1, 1, 0, 0, 0, 1, "R3");
    e(0); e(3, 8'hF2); e(3, 8'hC3); e(2); e(3, 8'hF3); e(4); e(5, 0, 0); e(1);
    cmp_log("R3 R7");
    chk(nrd == 1 && rd_log[0] == 8'h9E, "R3", "read byte", rd_log[0], 8'h9E);
  endtask

  task automatic t_len_ok();
    prep(); rx_src[0] = 8'h02; rx_src[1] = 8'h10; rx_src[2] = 8'h20;
    run(10'h050, 1, 0, 0, 0, 1, 1, "R8");
    e(0); e(3, 8'hA1); e(4); e(5, 0, 1); e(4); e(5, 0, 1); e(4); e(5, 0, 0); e(1);
    cmp_log("R8");
    chk(err == 0 && xfer_count == 3, "R8", "extended count", xfer_count, 3);
  endtask

  task automatic t_len_bad(input logic [7:0] v);
    prep(); rx_src[0] = v;
    run(10'h050, 1, 0, 0, 0, 1, 1, "R8");
    e(0); e(3, 8'hA1); e(4); e(5, 0, 0); e(1);
    cmp_log("R8");
    chk(err == 4, "R8", $sformatf("bad length %0d err", v), err, 4);
    chk(xfer_count == 1, "R8", "count", xfer_count, 1);
  endtask

  task automatic t_len_max();
    prep();
    for (int i = 0; i < 64; i++) rx_src[i] = 8'(i);
    rx_src[0] = 8'd32;
    run(10'h050, 1, 0, 0, 0, 1, 1, "R8");
    chk(ncmd == 69, "R8", "commands for 32", ncmd, 69);
    chk(lbit[67] == 0 && lbit[65] == 1, "R8", "last nak", lbit[67], 0);
    chk(err == 0 && xfer_count == 33, "R8", "count for 32", xfer_count, 33);
  endtask

  task automatic t_timeout();
    prep(); to_at = 2; wr_src[0] = 8'h44; wr_src[1] = 8'h45;
    run(10'h010, 0, 0, 0, 0, 0, 2, "R10");
    e(0); e(3, 8'h20); e(3, 8'h44); e(1);
    cmp_log("R10 R9");
    chk(err == 3, "R10", "timeout err", err, 3);
  endtask

  task automatic t_busy_start();
    int d0;
    prep(); wr_src[0] = 8'h66;
    d0 = ndone;
    pulse_start(10'h010, 0, 0, 0, 0, 0, 1);
    repeat (4) @(negedge clk);
    pulse_start(10'h033, 1, 0, 0, 0, 0, 2);
    wait_done(d0, "R12");
    e(0); e(3, 8'h20); e(3, 8'h66); e(1);
    cmp_log("R12");
    chk(ndone == d0 + 1, "R11", "single done pulse", ndone - d0, 1);
    repeat (20) @(negedge clk);
    chk(ndone == d0 + 1 && busy == 0, "R12", "no second message", ndone - d0, 1);
    chk(err == 0 && xfer_count == 1, "R11", "status held", xfer_count, 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    finish_run();
  end

  initial begin
    rst_n = 0; start = 0; addr = 0; rd = 0; ten_bit = 0; flip_dir = 0;
    ignore_nak = 0; recv_len = 0; len = 0;
    for (int i = 0; i < 16; i++) wr_src[i] = 8'h00;
    for (int i = 0; i < 64; i++) rx_src[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write7();
    t_read7_flip();
    t_retry_ok();
    t_retry_exhaust();
    t_ignore();
    t_data_nak();
    t_ten_write();
    t_ten_read();
    t_len_ok();
    t_len_bad(8'd0);
    t_len_bad(8'd33);
    t_len_max();
    t_timeout();
    t_busy_start();
    finish_run();
  end
endmodule